// File: doc/BRIEF.md
# Escalating Watchdog Timer

This watchdog counts edges of a slow, low-power time base. The time base reaches the block as a single-cycle tick in the system clock domain. Software restarts the count with a kick. If the count is allowed to reach the selected period, the block takes one of three actions, chosen by two enable bits:

- it raises an interrupt;
- it issues a system reset;
- it escalates: the first expiry raises an interrupt, and a second expiry that arrives while that interrupt is still pending issues a reset.

The single configuration register is protected. A write to it is accepted only within a short window that opens when a key byte is written to a separate key port. A fuse input can pin the watchdog in reset mode, where software cannot turn it off. A reset issued by the watchdog lasts exactly one system clock and sets a sticky cause flag. That flag stays set until software clears it.

Top module: `wdt_escalate`

## Requirements
- R1: The period is 2^(BASE_LOG+s) slow ticks, where s is the 4-bit select {cfg[5], cfg[2:0]} and any select above 9 acts as 9. The interrupt appears on the tick that completes the period, and the count then restarts from zero.
- R2: With cfg[6]=1 and cfg[3]=0 (interrupt mode), an expiry sets `irq`. The flag stays set through later expiries until `irq_ack`, and no reset is issued.
- R3: With cfg[3]=1 and cfg[6]=0 (reset mode), an expiry drives `wd_rst` high for exactly one system clock and sets `rst_cause`. `irq` stays low.
- R4: With cfg[6]=1 and cfg[3]=1 (escalating mode), the first expiry sets `irq`. An expiry while `irq` is still set issues the reset pulse and clears `irq`. If `irq_ack` arrives between the two expiries, the second expiry only raises `irq` again.
- R5: `kick` clears the count to zero. A kick on the same clock as the final tick wins, so no expiry happens on that tick.
- R6: A write to the configuration register is accepted only on one of the 4 clocks after the key byte 0xD8 is written. A write at any other time is ignored. An accepted write closes the window, and a key write with any other value closes it as well.
- R7: While `fuse_on` is high, the watchdog runs in reset mode whatever the stored configuration holds. In that state cfg[3] reads 1, cfg[6] reads 0, and `irq` is never raised.
- R8: Reserved bits cfg[7] and cfg[4] always read as zero.
- R9: `rst_cause` stays set until a `cause_clr` pulse. If a new watchdog reset arrives on the same clock as the clear, the set wins.
- R10: After `rst_n` is released, `cfg_rdata` is 0x00, `irq`, `wd_rst` and `rst_cause` are low, and the watchdog does not expire while both enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| slow_tick | input | 1 | One-clock pulse per slow time-base edge |
| kick | input | 1 | Restart the count |
| key_wr | input | 1 | Write strobe for the key byte |
| key_wdata | input | 8 | Key byte |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| irq_ack | input | 1 | Interrupt serviced; clears the pending flag |
| cause_clr | input | 1 | Clears the sticky reset-cause flag |
| fuse_on | input | 1 | Forces permanent reset mode |
| cfg_rdata | output | 8 | Configuration readback with the effective enables |
| irq | output | 1 | Pending watchdog interrupt |
| wd_rst | output | 1 | One-clock system reset request |
| rst_cause | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The bench targets the following corner cases:

- **Expiry tick.** It checks the tick just before expiry and the tick of expiry for selects 0, 1, 3, 5 and 9, and for the clamped values 10 and 15. An off-by-one counter, or a select that wraps instead of clamping, lands on the wrong tick.
- **Kick on the final tick.** A design that gives the expiry priority would fire there.
- **Escalation.** The bench checks escalation both with and without an acknowledge in between. A design that resets on the first expiry, or ignores the acknowledge, is caught.
- **Key window edges.** It writes on the fourth and the fifth clock after the key, writes a second time in the same window, and writes after a wrong key. A window that is one cycle long or short, or that is reusable, changes the readback.
- **Fuse.** With the fuse set, the bench tries to disable the watchdog and shows that it still resets.

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int         BASE_LOG = 11,
  parameter int         SEL_MAX  = 9,
  parameter int         CNT_W    = BASE_LOG + SEL_MAX,
  parameter logic [7:0] KEY      = 8'hD8,
  parameter int         WIN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       kick,
  input  logic       key_wr,
  input  logic [7:0] key_wdata,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       irq_ack,
  input  logic       cause_clr,
  input  logic       fuse_on,
  output logic [7:0] cfg_rdata,
  output logic       irq,
  output logic       wd_rst,
  output logic       rst_cause
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic             irq_en_q, rst_en_q, flag_q, rst_q, cause_q;
  logic [3:0]       sel_q, sel_c;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, limit;
  logic             irq_en, rst_en, enabled, hit, flag_eff, go_irq, go_rst, wr_ok;

  assign rst_en   = rst_en_q | fuse_on;
  assign irq_en   = irq_en_q & ~fuse_on;
  assign enabled  = rst_en | irq_en;
  assign sel_c    = (int'(sel_q) > SEL_MAX) ? 4'(SEL_MAX) : sel_q;
  assign limit    = CNT_W'((64'd1 << (BASE_LOG + int'(sel_c))) - 64'd1);
  assign hit      = enabled & slow_tick & ~kick & (cnt_q == limit);
  assign flag_eff = flag_q & ~irq_ack;
  assign go_irq   = hit & irq_en & ~(rst_en & flag_eff);
  assign go_rst   = hit & rst_en & (~irq_en | flag_eff);
  assign wr_ok    = cfg_wr & (win_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      sel_q    <= '0;
      win_q    <= '0;
    end else begin
      if (wr_ok) begin
        irq_en_q <= cfg_wdata[6];
        rst_en_q <= cfg_wdata[3];
        sel_q    <= {cfg_wdata[5], cfg_wdata[2:0]};
      end
      if (key_wr)                win_q <= (key_wdata == KEY) ? WIN_W'(WIN) : '0;
      else if (wr_ok)            win_q <= '0;
      else if (win_q != '0)      win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      rst_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (!enabled || kick || hit) cnt_q <= '0;
      else if (slow_tick)          cnt_q <= cnt_q + 1'b1;
      flag_q  <= go_irq ? 1'b1 : (go_rst ? 1'b0 : flag_eff);
      rst_q   <= go_rst;
      cause_q <= go_rst | (cause_q & ~cause_clr);
    end
  end

  assign cfg_rdata = {1'b0, irq_en, sel_q[3], 1'b0, rst_en, sel_q[2:0]};
  assign irq       = flag_q;
  assign wd_rst    = rst_q;
  assign rst_cause = cause_q;

  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  a_r3_cause_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> rst_cause);
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cause && !cause_clr) |=> rst_cause);
  a_r6_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0) |=> $stable({irq_en_q, rst_en_q, sel_q}));
  a_r7_fuse_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_on && !irq) |=> !irq);
  a_r2_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> (irq || wd_rst));
  a_r4_reset_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && irq_en && rst_en && !fuse_on) |-> $past(irq));
endmodule

// File: tb/wdt_escalate_test.sv
module wdt_escalate_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       slow_tick = 0, kick = 0, key_wr = 0, cfg_wr = 0, irq_ack = 0, cause_clr = 0, fuse_on = 0;
  logic [7:0] key_wdata = 0, cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       irq, wd_rst, rst_cause;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  wdt_escalate #(.BASE_LOG(3)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .kick(kick),
    .key_wr(key_wr), .key_wdata(key_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .irq_ack(irq_ack), .cause_clr(cause_clr), .fuse_on(fuse_on),
    .cfg_rdata(cfg_rdata), .irq(irq), .wd_rst(wd_rst), .rst_cause(rst_cause));

  // select, expected period in ticks (BASE_LOG = 3)
  localparam logic [19:0] VEC [0:6] = '{
    {4'd0, 16'd8}, {4'd1, 16'd16}, {4'd3, 16'd64}, {4'd5, 16'd256},
    {4'd9, 16'd4096}, {4'd10, 16'd4096}, {4'd15, 16'd4096}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    slow_tick = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic pulse_kick();  kick = 1;      @(negedge clk); kick = 0;      endtask
  task automatic pulse_ack();   irq_ack = 1;   @(negedge clk); irq_ack = 0;   endtask
  task automatic pulse_clr();   cause_clr = 1; @(negedge clk); cause_clr = 0; endtask

  task automatic put_key(logic [7:0] k);
    key_wr = 1; key_wdata = k; @(negedge clk); key_wr = 0;
  endtask

  task automatic put_cfg(logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; @(negedge clk); cfg_wr = 0;
  endtask

  task automatic write_cfg(logic [7:0] d);
    put_key(8'hD8); put_cfg(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cfg", cfg_rdata, 8'h00);
    check("R10 irq", irq, 0);
    check("R10 wd_rst", wd_rst, 0);
    check("R10 cause", rst_cause, 0);
    ticks(40);
    check("R10 disabled no expiry", {irq, wd_rst}, 2'b00);

    write_cfg(8'hFF);
    check("R8 reserved bits zero", cfg_rdata, 8'h6F);

    for (int i = 0; i < 7; i++) begin
      logic [3:0] s;
      s = VEC[i][19:16];
      write_cfg({1'b0, 1'b1, s[3], 1'b0, 1'b0, s[2:0]});
      pulse_kick();
      ticks(int'(VEC[i][15:0]) - 1);
      check("R1 before period", irq, 0);
      ticks(1);
      check("R1 at period", irq, 1);
      pulse_ack();
      check("R2 ack clears", irq, 0);
    end

    write_cfg(8'h40);
    pulse_kick();
    ticks(8);
    check("R2 irq set", irq, 1);
    ticks(8);
    check("R2 irq held", irq, 1);
    check("R2 no reset", {wd_rst, rst_cause}, 2'b00);
    pulse_ack();
    ticks(1);
    check("R1 count restarted after expiry", irq, 0);
    pulse_kick();

    ticks(6); pulse_kick(); ticks(7);
    check("R5 kick restarts", irq, 0);
    ticks(1);
    check("R5 expiry after kick", irq, 1);
    pulse_ack();
    ticks(7);
    kick = 1; slow_tick = 1; @(negedge clk); kick = 0; slow_tick = 0;
    check("R5 kick beats final tick", irq, 0);
    ticks(7);
    check("R5 count from zero", irq, 0);
    ticks(1);
    check("R5 expiry", irq, 1);
    pulse_ack();

    write_cfg(8'h08);
    pulse_kick();
    ticks(7);
    check("R3 no early reset", wd_rst, 0);
    ticks(1);
    check("R3 reset pulse", wd_rst, 1);
    check("R3 cause set", rst_cause, 1);
    check("R3 no irq", irq, 0);
    @(negedge clk);
    check("R3 pulse one clock", wd_rst, 0);
    repeat (5) @(negedge clk);
    check("R9 cause sticky", rst_cause, 1);
    pulse_clr();
    check("R9 cause cleared", rst_cause, 0);

    write_cfg(8'h48);
    pulse_kick();
    ticks(8);
    check("R4 first expiry irq", irq, 1);
    check("R4 first expiry no reset", rst_cause, 0);
    ticks(7);
    check("R4 no early reset", wd_rst, 0);
    ticks(1);
    check("R4 escalated reset", wd_rst, 1);
    check("R4 irq cleared", irq, 0);
    pulse_clr();
    pulse_kick();
    ticks(8);
    pulse_ack();
    ticks(8);
    check("R4 ack prevents reset", {irq, rst_cause}, 2'b10);
    pulse_ack();

    put_cfg(8'h00);
    check("R6 write without key", cfg_rdata, 8'h48);
    put_key(8'hD8);
    repeat (4) @(negedge clk);
    put_cfg(8'h00);
    check("R6 write after window", cfg_rdata, 8'h48);
    put_key(8'hD8);
    repeat (3) @(negedge clk);
    put_cfg(8'h49);
    check("R6 write on last window clock", cfg_rdata, 8'h49);
    put_cfg(8'h00);
    check("R6 window closed after write", cfg_rdata, 8'h49);
    put_key(8'h27);
    put_cfg(8'h00);
    check("R6 wrong key", cfg_rdata, 8'h49);

    fuse_on = 1;
    @(negedge clk);
    check("R7 fuse readback", cfg_rdata, 8'h09);
    write_cfg(8'h00);
    check("R7 cannot disable", cfg_rdata, 8'h08);
    pulse_kick();
    ticks(8);
    check("R7 reset with fuse", wd_rst, 1);
    check("R7 no irq with fuse", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule